// File: doc/BRIEF.md
# Transactional Read-Set Tracker with Requester-Wins Conflict Detection

This block follows which L1 cache lines each hardware thread's current transaction has loaded. It keeps one speculative mark per line per thread. A thread's transaction opens on a begin pulse. Each transactional load from that thread marks the line it touched. The transaction closes on commit, on a software abort, or on a failure that the block detects on its own.

Coherence requests that arrive from other agents are never held back. When a request clashes with a thread's transactional state, the request is serviced and the local transaction loses. The clash is one of two cases: an incoming write to a marked line, or any incoming request that the store queue reports as hitting a line the thread has written. The block then emits a one-cycle failure pulse for that thread, together with a cause code. An L1 eviction of a marked line also fails the transaction, and so does a translation miss on a transactional load. Both report a read-set cause. Every mark a thread holds is wiped in a single cycle whenever its transaction ends.

Top module: `rdset_tracker`

## Requirements
- R1: After reset, no thread is in a transaction, no failure pulse is raised, and every cause code reads 0.
- R2: A begin pulse to an idle thread makes its active flag read 1 one cycle later. A commit to an active thread makes the flag read 0 one cycle later, with no failure pulse.
- R3: A load marks its line only when its thread is active. A load that arrives while the thread is idle leaves nothing that a later eviction in a new transaction could fail on.
- R4: An incoming write to a line that an active thread has marked raises that thread's failure pulse one cycle later with cause 0x002 (bit 1). The active flag reads 0 in that same cycle.
- R5: An incoming read to a marked line, or an incoming write to an unmarked line, has no effect when the store queue reports no hit.
- R6: An incoming request of either type, when the store queue flags a hit for an active thread, fails that thread with cause 0x002.
- R7: Evicting a marked line fails the owning thread with cause 0x080 (bit 7). Evicting an unmarked line has no effect.
- R8: A transactional load that reports a translation miss fails the thread with cause 0x080.
- R9: Commit, software abort and failure each clear all of the thread's marks. A line marked in an earlier transaction cannot fail a later one.
- R10: Causes detected in the same cycle are OR-ed together into one code. A failure detected in the same cycle as a commit takes precedence over the commit.
- R11: The failure pulse lasts exactly one cycle. The cause code holds its value until the next failure of that thread.
- R12: Threads are independent. A conflict on one thread's marked line neither fails nor ends another thread's transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | THREADS | Per-thread transaction start pulse |
| tx_commit | input | THREADS | Per-thread commit pulse |
| tx_sw_abort | input | THREADS | Per-thread software abort (clears, no pulse) |
| ld_valid | input | 1 | Transactional load presented |
| ld_tid | input | TID_W | Thread issuing the load |
| ld_idx | input | IDX_W | L1 line index of the load |
| ld_tlb_miss | input | 1 | Load missed in the data translation buffer |
| snp_valid | input | 1 | Incoming coherence request presented |
| snp_idx | input | IDX_W | Line index of the incoming request |
| snp_is_write | input | 1 | Incoming request wants write ownership |
| sq_wr_hit | input | THREADS | Store queue: request hits a line this thread has written |
| ev_valid | input | 1 | L1 eviction presented |
| ev_idx | input | IDX_W | Line index being evicted |
| tx_active | output | THREADS | Per-thread transaction open flag |
| fail_pulse | output | THREADS | One-cycle failure strobe per thread |
| fail_cause | output | THREADS x 9 | Per-thread failure cause code, held |

## Verification
Incoming writes and reads are each aimed at marked and unmarked lines. This separates a true conflict from a request type or index that should pass harmlessly. A request that hits only the store queue shows that write-set clashes fail a transaction independently of the read marks. Evictions of lines that are marked, unmarked, and marked only in an earlier transaction show that the marks are tracked per line and wiped at every kind of transaction end. Stimulus with several causes at once, and with a commit racing a failure, fixes the OR-ing and the precedence. Traffic aimed at one thread while another is open shows that the threads are isolated.

// File: rtl/rdset_pkg.sv
package rdset_pkg;
    localparam int CAUSE_W = 9;
    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_CONFLICT = 9'h002;
    localparam cause_t CAUSE_READSET  = 9'h080;
    localparam cause_t CAUSE_LEGAL    = CAUSE_CONFLICT | CAUSE_READSET;

    typedef struct packed {
        logic   active;
        logic   pulse;
        cause_t cause;
    } ctl_state_t;
endpackage

// File: rtl/rdset_line_bits.sv
module rdset_line_bits #(
    parameter int LINES = 64,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [IDX_W-1:0] ev_idx,
    output logic             snp_hit,
    output logic             ev_hit
);
    logic [LINES-1:0] mark_d, mark_q;

    always_comb begin
        mark_d = mark_q;
        if (clr_all) begin
            mark_d = '0;
        end else if (set_en) begin
            mark_d[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= '0;
        end else begin
            mark_q <= mark_d;
        end
    end

    assign snp_hit = mark_q[snp_idx];
    assign ev_hit  = mark_q[ev_idx];

    // R9: a clear leaves no marks behind
    assert_marks_wiped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> ($countones(mark_q) == 0));

    // R3: a load into an open transaction leaves its line marked
    assert_load_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> mark_q[$past(set_idx)]);
endmodule

// File: rtl/rdset_thread_ctl.sv
module rdset_thread_ctl
    import rdset_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   begin_i,
    input  logic   commit_i,
    input  logic   sw_abort_i,
    input  logic   ld_mine,
    input  logic   ld_tlb_miss,
    input  logic   snp_valid,
    input  logic   snp_is_write,
    input  logic   snp_line_hit,
    input  logic   sq_wr_hit,
    input  logic   ev_valid,
    input  logic   ev_line_hit,
    output logic   set_en,
    output logic   clr_all,
    output logic   active_o,
    output logic   pulse_o,
    output cause_t cause_o
);
    ctl_state_t st_d, st_q;
    logic       coh_fail, rs_fail, any_fail;

    always_comb begin
        coh_fail = st_q.active && snp_valid &&
                   ((snp_is_write && snp_line_hit) || sq_wr_hit);
        rs_fail  = st_q.active &&
                   ((ev_valid && ev_line_hit) || (ld_mine && ld_tlb_miss));
        any_fail = coh_fail || rs_fail;

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (any_fail) begin
            st_d.active = 1'b0;
            st_d.pulse  = 1'b1;
            st_d.cause  = (coh_fail ? CAUSE_CONFLICT : '0) |
                          (rs_fail  ? CAUSE_READSET  : '0);
        end else if (st_q.active && (commit_i || sw_abort_i)) begin
            st_d.active = 1'b0;
        end else if (!st_q.active && begin_i) begin
            st_d.active = 1'b1;
        end

        set_en  = st_q.active && ld_mine && !ld_tlb_miss;
        clr_all = st_q.active && (any_fail || commit_i || sw_abort_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign pulse_o  = st_q.pulse;
    assign cause_o  = st_q.cause;

    // R4: a failing thread is already closed when its pulse shows
    assert_closed_on_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> !active_o);

    // R4: write to a marked line is a conflict
    assert_write_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && snp_valid && snp_is_write && snp_line_hit) |=> (pulse_o && cause_o[1]));

    // R7: eviction of a marked line is a read-set failure
    assert_evict_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && ev_valid && ev_line_hit) |=> (pulse_o && cause_o[7]));

    // R11: pulse is one cycle wide
    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R10: cause code carries only defined bits and is never empty on a pulse
    assert_cause_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> ((cause_o != '0) && ((cause_o & ~CAUSE_LEGAL) == '0)));

    // R2: a quiet commit closes without failure
    assert_quiet_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && commit_i && !snp_valid && !ev_valid && !ld_mine) |=> (!active_o && !pulse_o));
endmodule

// File: rtl/rdset_tracker.sv
module rdset_tracker
    import rdset_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int LINES   = 64,
    parameter int IDX_W   = $clog2(LINES),
    parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [THREADS-1:0]                tx_begin,
    input  logic [THREADS-1:0]                tx_commit,
    input  logic [THREADS-1:0]                tx_sw_abort,
    input  logic                              ld_valid,
    input  logic [TID_W-1:0]                  ld_tid,
    input  logic [IDX_W-1:0]                  ld_idx,
    input  logic                              ld_tlb_miss,
    input  logic                              snp_valid,
    input  logic [IDX_W-1:0]                  snp_idx,
    input  logic                              snp_is_write,
    input  logic [THREADS-1:0]                sq_wr_hit,
    input  logic                              ev_valid,
    input  logic [IDX_W-1:0]                  ev_idx,
    output logic [THREADS-1:0]                tx_active,
    output logic [THREADS-1:0]                fail_pulse,
    output logic [THREADS-1:0][CAUSE_W-1:0]   fail_cause
);
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic ld_mine, set_en, clr_all, snp_hit, ev_hit;

        assign ld_mine = ld_valid && (ld_tid == TID_W'(t));

        rdset_line_bits #(.LINES(LINES), .IDX_W(IDX_W)) u_bits (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (set_en),
            .set_idx (ld_idx),
            .clr_all (clr_all),
            .snp_idx (snp_idx),
            .ev_idx  (ev_idx),
            .snp_hit (snp_hit),
            .ev_hit  (ev_hit)
        );

        rdset_thread_ctl u_ctl (
            .clk          (clk),
            .rst_n        (rst_n),
            .begin_i      (tx_begin[t]),
            .commit_i     (tx_commit[t]),
            .sw_abort_i   (tx_sw_abort[t]),
            .ld_mine      (ld_mine),
            .ld_tlb_miss  (ld_tlb_miss),
            .snp_valid    (snp_valid),
            .snp_is_write (snp_is_write),
            .snp_line_hit (snp_hit),
            .sq_wr_hit    (sq_wr_hit[t]),
            .ev_valid     (ev_valid),
            .ev_line_hit  (ev_hit),
            .set_en       (set_en),
            .clr_all      (clr_all),
            .active_o     (tx_active[t]),
            .pulse_o      (fail_pulse[t]),
            .cause_o      (fail_cause[t])
        );
    end
endmodule

// File: tb/tb_rdset_tracker.sv
module tb_rdset_tracker;
    localparam int THREADS = 2;
    localparam int LINES   = 64;
    localparam int IDX_W   = 6;
    localparam int TID_W   = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [THREADS-1:0] tx_begin, tx_commit, tx_sw_abort, sq_wr_hit;
    logic ld_valid, ld_tlb_miss, snp_valid, snp_is_write, ev_valid;
    logic [TID_W-1:0] ld_tid;
    logic [IDX_W-1:0] ld_idx, snp_idx, ev_idx;
    logic [THREADS-1:0] tx_active, fail_pulse;
    logic [THREADS-1:0][8:0] fail_cause;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    rdset_tracker #(.THREADS(THREADS), .LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_sw_abort(tx_sw_abort),
        .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_idx(ld_idx), .ld_tlb_miss(ld_tlb_miss),
        .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_is_write(snp_is_write),
        .sq_wr_hit(sq_wr_hit), .ev_valid(ev_valid), .ev_idx(ev_idx),
        .tx_active(tx_active), .fail_pulse(fail_pulse), .fail_cause(fail_cause)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tx_begin = '0; tx_commit = '0; tx_sw_abort = '0; sq_wr_hit = '0;
        ld_valid = 0; ld_tid = '0; ld_idx = '0; ld_tlb_miss = 0;
        snp_valid = 0; snp_idx = '0; snp_is_write = 0;
        ev_valid = 0; ev_idx = '0;
    endtask

    // apply current inputs for one edge, then return to idle at the next negedge
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic open_tx(input int t);
        tx_begin[t] = 1'b1; step();
    endtask

    task automatic load(input int t, input int idx);
        ld_valid = 1; ld_tid = TID_W'(t); ld_idx = IDX_W'(idx); step();
    endtask

    task automatic end_all();
        tx_sw_abort = '1; step();
    endtask

    task automatic t_reset();
        chk(tx_active == 0, "R1", "active after reset", 32'(tx_active), 0);
        chk(fail_pulse == 0, "R1", "pulse after reset", 32'(fail_pulse), 0);
        chk(fail_cause == 0, "R1", "cause after reset", 32'(fail_cause), 0);
    endtask

    task automatic t_begin_commit();
        open_tx(0);
        chk(tx_active[0] == 1, "R2", "active after begin", 32'(tx_active[0]), 1);
        tx_commit[0] = 1; step();
        chk(tx_active[0] == 0, "R2", "active after commit", 32'(tx_active[0]), 0);
        chk(fail_pulse[0] == 0, "R2", "pulse after commit", 32'(fail_pulse[0]), 0);
    endtask

    task automatic t_write_conflict();
        open_tx(0);
        load(0, 5);
        snp_valid = 1; snp_idx = 5; snp_is_write = 1; step();
        chk(fail_pulse[0] == 1, "R4", "pulse on write conflict", 32'(fail_pulse[0]), 1);
        chk(fail_cause[0] == 9'h002, "R4", "cause on write conflict", 32'(fail_cause[0]), 32'h002);
        chk(tx_active[0] == 0, "R4", "active on conflict", 32'(tx_active[0]), 0);
        step();
        chk(fail_pulse[0] == 0, "R11", "pulse width", 32'(fail_pulse[0]), 0);
        chk(fail_cause[0] == 9'h002, "R11", "cause held", 32'(fail_cause[0]), 32'h002);
    endtask

    task automatic t_harmless_snoops();
        open_tx(0);
        load(0, 9);
        snp_valid = 1; snp_idx = 9; snp_is_write = 0; step();
        chk(fail_pulse[0] == 0, "R5", "read to marked line", 32'(fail_pulse[0]), 0);
        snp_valid = 1; snp_idx = 10; snp_is_write = 1; step();
        chk(fail_pulse[0] == 0, "R5", "write to unmarked line", 32'(fail_pulse[0]), 0);
        chk(tx_active[0] == 1, "R5", "still active", 32'(tx_active[0]), 1);
        end_all();
    endtask

    task automatic t_store_queue_hit();
        open_tx(0);
        snp_valid = 1; snp_idx = 3; snp_is_write = 0; sq_wr_hit[0] = 1; step();
        chk(fail_pulse[0] == 1, "R6", "pulse on write-set read", 32'(fail_pulse[0]), 1);
        chk(fail_cause[0] == 9'h002, "R6", "cause on write-set read", 32'(fail_cause[0]), 32'h002);
    endtask

    task automatic t_evict();
        open_tx(0);
        load(0, 12);
        ev_valid = 1; ev_idx = 13; step();
        chk(fail_pulse[0] == 0 && tx_active[0] == 1, "R7", "unmarked eviction",
            32'({fail_pulse[0], tx_active[0]}), 32'b01);
        ev_valid = 1; ev_idx = 12; step();
        chk(fail_pulse[0] == 1, "R7", "marked eviction pulse", 32'(fail_pulse[0]), 1);
        chk(fail_cause[0] == 9'h080, "R7", "marked eviction cause", 32'(fail_cause[0]), 32'h080);
    endtask

    task automatic t_tlb_miss();
        open_tx(1);
        ld_valid = 1; ld_tid = 1; ld_idx = 7; ld_tlb_miss = 1; step();
        chk(fail_pulse[1] == 1, "R8", "pulse on translation miss", 32'(fail_pulse[1]), 1);
        chk(fail_cause[1] == 9'h080, "R8", "cause on translation miss", 32'(fail_cause[1]), 32'h080);
    endtask

    task automatic t_clearing();
        // commit clears
        open_tx(0); load(0, 20);
        tx_commit[0] = 1; step();
        open_tx(0);
        ev_valid = 1; ev_idx = 20; step();
        chk(fail_pulse[0] == 0, "R9", "line from committed tx", 32'(fail_pulse[0]), 0);
        // software abort clears
        load(0, 21);
        tx_sw_abort[0] = 1; step();
        chk(fail_pulse[0] == 0 && tx_active[0] == 0, "R9", "sw abort silent",
            32'({fail_pulse[0], tx_active[0]}), 0);
        open_tx(0);
        snp_valid = 1; snp_idx = 21; snp_is_write = 1; step();
        chk(fail_pulse[0] == 0, "R9", "line from aborted tx", 32'(fail_pulse[0]), 0);
        // failure clears
        load(0, 22); load(0, 23);
        ev_valid = 1; ev_idx = 22; step();
        open_tx(0);
        ev_valid = 1; ev_idx = 23; step();
        chk(fail_pulse[0] == 0, "R9", "line from failed tx", 32'(fail_pulse[0]), 0);
        end_all();
        // idle load marks nothing
        load(1, 50);
        open_tx(1);
        ev_valid = 1; ev_idx = 50; step();
        chk(fail_pulse[1] == 0, "R3", "load while idle", 32'(fail_pulse[1]), 0);
        end_all();
    endtask

    task automatic t_combined();
        open_tx(0); load(0, 30);
        snp_valid = 1; snp_idx = 30; snp_is_write = 1; ev_valid = 1; ev_idx = 30; step();
        chk(fail_cause[0] == 9'h082, "R10", "merged causes", 32'(fail_cause[0]), 32'h082);
        open_tx(0); load(0, 31);
        tx_commit[0] = 1; ev_valid = 1; ev_idx = 31; step();
        chk(fail_pulse[0] == 1, "R10", "failure beats commit", 32'(fail_pulse[0]), 1);
        chk(fail_cause[0] == 9'h080, "R10", "cause when racing commit", 32'(fail_cause[0]), 32'h080);
    endtask

    task automatic t_threads();
        tx_begin = 2'b11; step();
        load(0, 40);
        snp_valid = 1; snp_idx = 40; snp_is_write = 1; step();
        chk(fail_pulse == 2'b01, "R12", "only owner fails", 32'(fail_pulse), 32'b01);
        chk(tx_active[1] == 1, "R12", "other thread stays open", 32'(tx_active[1]), 1);
        end_all();
    endtask

    initial begin
        #(5.0 * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_begin_commit();
        t_write_conflict();
        t_harmless_snoops();
        t_store_queue_hit();
        t_evict();
        t_tlb_miss();
        t_clearing();
        t_combined();
        t_threads();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule